// File: doc/BRIEF.md
# Byte-serial multiply-divide accelerator

This block is an arithmetic coprocessor for a small 8-bit peripheral bus. The bus has a 2-bit address, write and read strobes, and byte-wide data lines. A host loads operands one byte at a time into three data ports: a 32-bit operand port A, a 16-bit operand port B and a 40-bit accumulator port. There is no opcode. The block works out the operation from the order in which A and B are written, and starts one of three unsigned operations: a 16x16 multiply, a 32/16 divide or a 16/16 divide.

Each port keeps its own byte pointer, and every access moves that pointer. Bytes are written least significant first and read back most significant first. When an operation finishes, its product or quotient goes into A, a remainder goes into B, and the product or quotient is also added into the 40-bit accumulator. This lets the host chain multiply-accumulate or divide-accumulate steps. A status register shows the busy and overflow flags and provides a clear-all command. The operation runs on a shift-and-add or shift-and-subtract engine that takes one bit per clock. The busy window is stretched to a fixed latency for each kind of operation, so the host can wait a known number of cycles instead of polling.

Top module: `muldiv_accel`

## Requirements
- R1: Address 0 is status, 1 is port A, 2 is port B and 3 is the accumulator. A port that was just loaded reads back its written bytes most significant first, starting from the last byte written.
- R2: Two writes to B and then two writes to A start a 16x16 multiply of the A word by the B word. Afterwards, four reads of A return the 32-bit product, most significant byte first.
- R3: Four writes to A and then two writes to B start a 32/16 divide. Four reads of A then return the quotient and two reads of B return the 16-bit remainder, most significant byte first.
- R4: Two writes to A and then two writes to B start a 16/16 divide. Two reads of A then return the 16-bit quotient and two reads of B return the remainder.
- R5: Status bit 7 (busy) is 1 for exactly 24 cycles for a multiply or a 16/16 divide and for 36 cycles for a 32/16 divide. It rises in the cycle after the last write of the sequence, and the results can be read once it is 0.
- R6: At the end of each multiply, status bit 6 (overflow) becomes 1 if the product exceeds 0000FFFFh and 0 otherwise.
- R7: A divide by a zero divisor sets status bit 6 to 1, leaves the quotient and remainder at all ones, and leaves the accumulator unchanged. A divide with a nonzero divisor sets status bit 6 to 0.
- R8: Each multiply adds its product, and each divide with a nonzero divisor adds its quotient, into the 40-bit accumulator modulo 2^40.
- R9: Five writes to the accumulator port load it, least significant byte first. Five reads return it most significant byte first.
- R10: Writing the status register with bit 4 set clears A, B and the accumulator, and restarts the sequence tracker.
- R11: A write that does not continue a defined sequence starts no operation. The tracker restarts its match from that write, so a later valid sequence still starts.
- R12: While busy is 1, writes to every register, including the clear command, have no effect.
- R13: After reset, status reads 00h and A, B and the accumulator read all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register select |
| wr_i | input | 1 | Write strobe; the write happens on the rising clock edge |
| rd_i | input | 1 | Read strobe; advances the byte pointer of the selected port |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the selected register at its current byte pointer |

## Verification
The bench puts interleaved A and B writes through the tracker. If the tracker failed to restart on a stray write, the later valid tail would either start nothing or divide by stale bytes. It loads an all-ones accumulator before a multiply by one, so an adder narrower than 40 bits or one that saturates leaves a wrong value instead of wrapping to zero. A zero divisor must leave the accumulator alone. A design that adds the all-ones quotient would show it directly. The bench also issues data writes and a clear while busy. Any leak through the busy gate would corrupt the pending result or wipe the accumulator.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  localparam int BYTE_W  = 8;
  localparam int A_W     = 32;
  localparam int B_W     = 16;
  localparam int ACC_W   = 40;
  localparam int ADR_W   = 2;
  localparam int ACC_NB  = ACC_W / BYTE_W;

  localparam logic [ADR_W-1:0] ADR_STAT = 2'd0;
  localparam logic [ADR_W-1:0] ADR_A    = 2'd1;
  localparam logic [ADR_W-1:0] ADR_B    = 2'd2;
  localparam logic [ADR_W-1:0] ADR_ACC  = 2'd3;

  localparam int STAT_BUSY = 7;
  localparam int STAT_OVF  = 6;
  localparam int STAT_CLR  = 4;

  typedef enum logic [1:0] {
    OP_MUL   = 2'd0,
    OP_DIV16 = 2'd1,
    OP_DIV32 = 2'd2
  } op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_A1, S_A2, S_A3, S_A4, S_A2B1, S_A4B1, S_B1, S_B2, S_B2A1
  } seq_e;
endpackage

// File: rtl/muldiv_seq.sv
module muldiv_seq
  import muldiv_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_a_i,
  input  logic       wr_b_i,
  input  logic       clr_i,
  output logic [1:0] a_idx_o,
  output logic       b_idx_o,
  output logic       start_o,
  output op_e        op_o
);
  seq_e st_q, st_d;

  always_comb begin
    st_d    = st_q;
    start_o = 1'b0;
    op_o    = OP_MUL;
    if (wr_a_i) begin
      case (st_q)
        S_A1:   st_d = S_A2;
        S_A2:   st_d = S_A3;
        S_A3:   st_d = S_A4;
        S_B2:   st_d = S_B2A1;
        S_B2A1: begin start_o = 1'b1; op_o = OP_MUL; st_d = S_IDLE; end
        default: st_d = S_A1;  // restart match at this write
      endcase
    end else if (wr_b_i) begin
      case (st_q)
        S_B1:   st_d = S_B2;
        S_A2:   st_d = S_A2B1;
        S_A4:   st_d = S_A4B1;
        S_A2B1: begin start_o = 1'b1; op_o = OP_DIV16; st_d = S_IDLE; end
        S_A4B1: begin start_o = 1'b1; op_o = OP_DIV32; st_d = S_IDLE; end
        default: st_d = S_B1;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    st_q <= S_IDLE;
    else if (clr_i) st_q <= S_IDLE;
    else            st_q <= st_d;
  end

  // byte slot the next write lands in, derived from match progress
  always_comb begin
    case (st_q)
      S_A1, S_B2A1: a_idx_o = 2'd1;
      S_A2:         a_idx_o = 2'd2;
      S_A3:         a_idx_o = 2'd3;
      default:      a_idx_o = 2'd0;
    endcase
    b_idx_o = (st_q == S_B1) || (st_q == S_A2B1) || (st_q == S_A4B1);
  end

  p_seq_restart_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> (st_q == S_IDLE));
  p_clr_restart_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (st_q == S_IDLE));
endmodule

// File: rtl/muldiv_core.sv
module muldiv_core
  import muldiv_pkg::*;
#(
  parameter int LAT_MUL   = 24,
  parameter int LAT_DIV16 = 24,
  parameter int LAT_DIV32 = 36
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  op_e            op_i,
  input  logic [A_W-1:0] a_i,
  input  logic [B_W-1:0] b_i,
  output logic           busy_o,
  output logic           fin_o,
  output op_e            op_o,
  output logic [A_W-1:0] res_o,
  output logic [B_W-1:0] rem_o,
  output logic           ovf_o,
  output logic           dz_o
);
  localparam int LAT_MAX = (LAT_DIV32 > LAT_MUL) ?
                           ((LAT_DIV32 > LAT_DIV16) ? LAT_DIV32 : LAT_DIV16) :
                           ((LAT_MUL > LAT_DIV16) ? LAT_MUL : LAT_DIV16);
  localparam int CNT_W   = $clog2(LAT_MAX + 1);
  localparam int STEP_W  = $clog2(A_W + 1);

  logic              busy_q;
  op_e               op_q;
  logic [CNT_W-1:0]  cnt_q, lat_q;
  logic [STEP_W-1:0] nstep_q;
  logic [A_W-1:0]    work_q, aux_q;   // mul: product, multiplicand; div: quotient/dividend
  logic [B_W-1:0]    mplr_q, rem_q, dvs_q;

  logic [A_W-1:0]    work_n, aux_n;
  logic [B_W-1:0]    mplr_n, rem_n;
  logic [B_W:0]      r_sh;
  logic              qbit, stepping;

  always_comb begin
    work_n = work_q;
    aux_n  = aux_q;
    mplr_n = mplr_q;
    rem_n  = rem_q;
    r_sh   = {rem_q, work_q[A_W-1]};
    qbit   = 1'b0;
    if (op_q == OP_MUL) begin
      if (mplr_q[0]) work_n = work_q + aux_q;
      aux_n  = {aux_q[A_W-2:0], 1'b0};
      mplr_n = {1'b0, mplr_q[B_W-1:1]};
    end else begin
      qbit   = (r_sh >= {1'b0, dvs_q});
      rem_n  = qbit ? (r_sh[B_W-1:0] - dvs_q) : r_sh[B_W-1:0];
      work_n = {work_q[A_W-2:0], qbit};
    end
  end

  assign stepping = busy_q && (32'(cnt_q) < 32'(nstep_q));
  assign fin_o    = busy_q && (cnt_q == lat_q - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      op_q    <= OP_MUL;
      cnt_q   <= '0;
      lat_q   <= CNT_W'(LAT_MUL);
      nstep_q <= '0;
      work_q  <= '0;
      aux_q   <= '0;
      mplr_q  <= '0;
      rem_q   <= '0;
      dvs_q   <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      op_q   <= op_i;
      cnt_q  <= '0;
      rem_q  <= '0;
      case (op_i)
        OP_MUL: begin
          lat_q   <= CNT_W'(LAT_MUL);
          nstep_q <= STEP_W'(B_W);
          work_q  <= '0;
          aux_q   <= {{(A_W-B_W){1'b0}}, a_i[B_W-1:0]};
          mplr_q  <= b_i;
        end
        OP_DIV16: begin
          lat_q   <= CNT_W'(LAT_DIV16);
          nstep_q <= STEP_W'(B_W);
          work_q  <= {a_i[B_W-1:0], {(A_W-B_W){1'b0}}};
          dvs_q   <= b_i;
        end
        default: begin
          lat_q   <= CNT_W'(LAT_DIV32);
          nstep_q <= STEP_W'(A_W);
          work_q  <= a_i;
          dvs_q   <= b_i;
        end
      endcase
    end else if (busy_q) begin
      cnt_q <= cnt_q + CNT_W'(1);
      if (fin_o) busy_q <= 1'b0;
      if (stepping) begin
        work_q <= work_n;
        aux_q  <= aux_n;
        mplr_q <= mplr_n;
        rem_q  <= rem_n;
      end
    end
  end

  assign busy_o = busy_q;
  assign op_o   = op_q;
  assign dz_o   = (op_q != OP_MUL) && (dvs_q == '0);
  assign res_o  = dz_o ? '1 : work_q;
  assign rem_o  = dz_o ? '1 : rem_q;
  assign ovf_o  = (op_q == OP_MUL) ? (work_q[A_W-1:B_W] != '0) : dz_o;

  p_no_start_busy_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q);
  p_start_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_q);
  p_steps_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_o |-> !stepping);
endmodule

// File: rtl/muldiv_accel.sv
module muldiv_accel
  import muldiv_pkg::*;
#(
  parameter int LAT_MUL   = 24,
  parameter int LAT_DIV16 = 24,
  parameter int LAT_DIV32 = 36
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADR_W-1:0]  addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o
);
  localparam logic [2:0] ACC_TOP = 3'(ACC_NB - 1);

  logic [A_W-1:0]   a_q, a_nxt, res;
  logic [B_W-1:0]   b_q, b_nxt, rem;
  logic [ACC_W-1:0] acc_q;
  logic             ovf_q;
  logic [1:0]       a_rp_q;
  logic             b_rp_q;
  logic [2:0]       acc_wp_q, acc_rp_q;

  logic       busy, fin, ovf, dz, start;
  op_e        op_start, op_run;
  logic [1:0] a_idx;
  logic       b_idx;
  logic       wr_ok, wr_a, wr_b, wr_acc, clr, rd_a, rd_b, rd_acc;

  assign wr_ok  = wr_i && !busy;
  assign wr_a   = wr_ok && (addr_i == ADR_A);
  assign wr_b   = wr_ok && (addr_i == ADR_B);
  assign wr_acc = wr_ok && (addr_i == ADR_ACC);
  assign clr    = wr_ok && (addr_i == ADR_STAT) && wdata_i[STAT_CLR];
  assign rd_a   = rd_i && (addr_i == ADR_A);
  assign rd_b   = rd_i && (addr_i == ADR_B);
  assign rd_acc = rd_i && (addr_i == ADR_ACC);

  muldiv_seq i_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_a_i  (wr_a),
    .wr_b_i  (wr_b),
    .clr_i   (clr),
    .a_idx_o (a_idx),
    .b_idx_o (b_idx),
    .start_o (start),
    .op_o    (op_start)
  );

  // operand values including the byte written this cycle
  always_comb begin
    a_nxt = a_q;
    b_nxt = b_q;
    if (wr_a) begin
      if (a_idx == 2'd0) a_nxt = {{(A_W-BYTE_W){1'b0}}, wdata_i};
      else               a_nxt[{a_idx, 3'b000} +: BYTE_W] = wdata_i;
    end
    if (wr_b) begin
      if (!b_idx) b_nxt = {{(B_W-BYTE_W){1'b0}}, wdata_i};
      else        b_nxt = {wdata_i, b_q[BYTE_W-1:0]};
    end
  end

  muldiv_core #(
    .LAT_MUL   (LAT_MUL),
    .LAT_DIV16 (LAT_DIV16),
    .LAT_DIV32 (LAT_DIV32)
  ) i_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .op_i    (op_start),
    .a_i     (a_nxt),
    .b_i     (b_nxt),
    .busy_o  (busy),
    .fin_o   (fin),
    .op_o    (op_run),
    .res_o   (res),
    .rem_o   (rem),
    .ovf_o   (ovf),
    .dz_o    (dz)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q      <= '0;
      b_q      <= '0;
      acc_q    <= '0;
      ovf_q    <= 1'b0;
      a_rp_q   <= 2'd3;
      b_rp_q   <= 1'b1;
      acc_wp_q <= '0;
      acc_rp_q <= ACC_TOP;
    end else if (clr) begin
      a_q      <= '0;
      b_q      <= '0;
      acc_q    <= '0;
      a_rp_q   <= 2'd3;
      b_rp_q   <= 1'b1;
      acc_wp_q <= '0;
      acc_rp_q <= ACC_TOP;
    end else if (fin) begin
      a_q      <= res;
      ovf_q    <= ovf;
      a_rp_q   <= (op_run == OP_DIV16) ? 2'd1 : 2'd3;
      acc_wp_q <= '0;
      acc_rp_q <= ACC_TOP;
      if (op_run != OP_MUL) begin
        b_q    <= rem;
        b_rp_q <= 1'b1;
      end
      if (!dz) acc_q <= acc_q + {{(ACC_W-A_W){1'b0}}, res};
    end else begin
      a_q <= a_nxt;
      b_q <= b_nxt;
      if (wr_a)      a_rp_q <= a_idx;
      else if (rd_a) a_rp_q <= a_rp_q - 2'd1;
      if (wr_b)      b_rp_q <= b_idx;
      else if (rd_b) b_rp_q <= ~b_rp_q;
      if (wr_acc) begin
        acc_q[{acc_wp_q, 3'b000} +: BYTE_W] <= wdata_i;
        acc_rp_q <= acc_wp_q;
        acc_wp_q <= (acc_wp_q == ACC_TOP) ? 3'd0 : acc_wp_q + 3'd1;
      end else if (rd_acc) begin
        acc_rp_q <= (acc_rp_q == 3'd0) ? ACC_TOP : acc_rp_q - 3'd1;
      end
    end
  end

  always_comb begin
    case (addr_i)
      ADR_A:   rdata_o = a_q[{a_rp_q, 3'b000} +: BYTE_W];
      ADR_B:   rdata_o = b_rp_q ? b_q[B_W-1:BYTE_W] : b_q[BYTE_W-1:0];
      ADR_ACC: rdata_o = acc_q[{acc_rp_q, 3'b000} +: BYTE_W];
      default: begin
        rdata_o = '0;
        rdata_o[STAT_BUSY] = busy;
        rdata_o[STAT_OVF]  = ovf_q;
      end
    endcase
  end

  // busy-window length watcher
  logic [7:0] busy_len_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   busy_len_q <= '0;
    else if (busy) busy_len_q <= busy_len_q + 8'd1;
    else           busy_len_q <= '0;
  end

  p_latency_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> (32'(busy_len_q) ==
      ((op_run == OP_DIV32) ? LAT_DIV32 : (op_run == OP_DIV16) ? LAT_DIV16 : LAT_MUL)));
  p_no_overflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin && op_run == OP_MUL) |=> (ovf_q == (a_q[A_W-1:B_W] != '0)));
  p_div_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin && dz) |=> (a_q == '1 && b_q == '1 && ovf_q && $stable(acc_q)));
  p_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> (a_q == '0 && b_q == '0 && acc_q == '0));
  p_busy_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !fin) |=> ($stable(acc_q) && $stable(b_q) && $stable(a_q)));
endmodule

// File: tb/test_muldiv_accel.sv
`timescale 1ns/1ps
module test_muldiv_accel;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] addr_i = '0;
  logic       wr_i = 1'b0;
  logic       rd_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;

  int n_chk = 0;
  int n_err = 0;
  logic [39:0] model_acc;

  always #10 clk_i = ~clk_i;

  muldiv_accel i_muldiv_accel (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .wr_i    (wr_i),
    .rd_i    (rd_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o)
  );

  // op, a, b
  localparam int NV = 8;
  localparam logic [49:0] VEC [NV] = '{
    {2'd0, 32'h0000_1234, 16'h5678},
    {2'd2, 32'h5678_5678, 16'h1234},
    {2'd1, 32'h0000_5678, 16'h1234},
    {2'd0, 32'h0000_FFFF, 16'hFFFF},
    {2'd0, 32'h0000_00FF, 16'h0100},
    {2'd2, 32'hFFFF_FFFF, 16'h0001},
    {2'd1, 32'h0000_0005, 16'h0007},
    {2'd2, 32'h8000_0000, 16'hFFFF}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(posedge clk_i); #1 wr_i = 1'b0;
  endtask

  task automatic rd_bytes(input logic [1:0] a, input int n, output logic [39:0] v);
    v = '0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      addr_i = a; rd_i = 1'b1;
      #1 v = {v[31:0], rdata_o};
      @(posedge clk_i); #1 rd_i = 1'b0;
    end
  endtask

  task automatic peek_stat(output logic [7:0] s);
    @(negedge clk_i);
    addr_i = 2'd0;
    #1 s = rdata_o;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    addr_i = 2'd0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk_i);
      #1;
      if (!rdata_o[7]) break;
      n++;
    end
  endtask

  task automatic wr_bytes(input logic [1:0] a, input logic [39:0] v, input int n);
    for (int i = 0; i < n; i++) wr(a, v[8*i +: 8]);
  endtask

  task automatic do_clear();
    wr(2'd0, 8'h10);
    model_acc = '0;
  endtask

  initial begin
    #4_000_000;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [39:0] v;
    logic [7:0]  s;
    int          n;
    model_acc = '0;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // R13 reset state
    peek_stat(s);           check("R13 status", 64'(s), 64'h00);
    rd_bytes(2'd1, 4, v);   check("R13 A", 64'(v), 64'h0);
    rd_bytes(2'd2, 2, v);   check("R13 B", 64'(v), 64'h0);
    rd_bytes(2'd3, 5, v);   check("R13 acc", 64'(v), 64'h0);

    // R1 load/readback order
    wr_bytes(2'd1, 40'h44332211, 4);
    rd_bytes(2'd1, 4, v);   check("R1 A readback", 64'(v), 64'h44332211);
    do_clear();
    wr_bytes(2'd2, 40'hCDAB, 2);
    rd_bytes(2'd2, 2, v);   check("R1 B readback", 64'(v), 64'hCDAB);
    peek_stat(s);           check("R1 no op started", 64'(s[7]), 64'h0);
    do_clear();

    // vector table: R2 R3 R4 R5 R6 R8
    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op;
      logic [31:0] a, q;
      logic [15:0] b, r;
      int          lat, nb;
      string       tg;
      op = VEC[i][49:48]; a = VEC[i][47:16]; b = VEC[i][15:0];
      if (op == 2'd0) begin
        wr_bytes(2'd2, 40'(b), 2); wr_bytes(2'd1, 40'(a[15:0]), 2);
        q = 32'(a[15:0]) * 32'(b); r = b; lat = 24; nb = 4; tg = "R2";
      end else if (op == 2'd1) begin
        wr_bytes(2'd1, 40'(a[15:0]), 2); wr_bytes(2'd2, 40'(b), 2);
        q = 32'(a[15:0] / b); r = a[15:0] % b; lat = 24; nb = 2; tg = "R4";
      end else begin
        wr_bytes(2'd1, 40'(a), 4); wr_bytes(2'd2, 40'(b), 2);
        q = a / 32'(b); r = 16'(a % 32'(b)); lat = 36; nb = 4; tg = "R3";
      end
      model_acc = model_acc + 40'(q);
      wait_done(n);
      check($sformatf("R5 latency vec%0d", i), 64'(n), 64'(lat));
      rd_bytes(2'd1, nb, v);
      check($sformatf("%s result vec%0d", tg, i), 64'(v), 64'(q));
      if (op != 2'd0) begin
        rd_bytes(2'd2, 2, v);
        check($sformatf("%s remainder vec%0d", tg, i), 64'(v), 64'(r));
      end
      peek_stat(s);
      check($sformatf("R6 ovf vec%0d", i), 64'(s[6]), (op == 2'd0) ? 64'(q > 32'hFFFF) : 64'h0);
      rd_bytes(2'd3, 5, v);
      check($sformatf("R8 acc vec%0d", i), 64'(v), 64'(model_acc));
    end

    // R9 accumulator load/read
    wr_bytes(2'd3, 40'h01_0203_0405, 5);
    rd_bytes(2'd3, 5, v);   check("R9 acc load", 64'(v), 64'h0102030405);

    // R8 wrap
    wr_bytes(2'd3, 40'hFF_FFFF_FFFF, 5);
    wr_bytes(2'd2, 40'h1, 2); wr_bytes(2'd1, 40'h1, 2);
    wait_done(n);
    rd_bytes(2'd3, 5, v);   check("R8 acc wrap", 64'(v), 64'h0);

    // R10 clear zeroes and restarts tracker
    wr_bytes(2'd1, 40'h5566, 2);
    wr_bytes(2'd3, 40'h77, 1);
    do_clear();
    rd_bytes(2'd1, 4, v);   check("R10 A cleared", 64'(v), 64'h0);
    rd_bytes(2'd3, 5, v);   check("R10 acc cleared", 64'(v), 64'h0);
    wr_bytes(2'd1, 40'h0009, 2);
    do_clear();
    wr_bytes(2'd2, 40'h0003, 2);
    peek_stat(s);           check("R10 tracker restarted", 64'(s[7]), 64'h0);
    do_clear();

    // R11 stray writes
    wr(2'd1, 8'h11); wr(2'd2, 8'h22); wr(2'd1, 8'h33); wr(2'd1, 8'h44);
    peek_stat(s);           check("R11 no op on mismatch", 64'(s[7]), 64'h0);
    wr(2'd2, 8'h02); wr(2'd2, 8'h00);
    wait_done(n);           check("R11 later div16 latency", 64'(n), 64'd24);
    rd_bytes(2'd1, 2, v);   check("R11 quotient", 64'(v), 64'h2219);
    rd_bytes(2'd2, 2, v);   check("R11 remainder", 64'(v), 64'h0001);

    // R7 divide by zero
    do_clear();
    wr_bytes(2'd2, 40'h3, 2); wr_bytes(2'd1, 40'h2, 2);
    wait_done(n);
    wr_bytes(2'd1, 40'h1234, 2); wr_bytes(2'd2, 40'h0, 2);
    wait_done(n);
    peek_stat(s);           check("R7 ovf on zero divisor", 64'(s[6]), 64'h1);
    rd_bytes(2'd1, 2, v);   check("R7 quotient ones", 64'(v), 64'hFFFF);
    rd_bytes(2'd2, 2, v);   check("R7 remainder ones", 64'(v), 64'hFFFF);
    rd_bytes(2'd3, 5, v);   check("R7 acc unchanged", 64'(v), 64'h6);
    wr_bytes(2'd1, 40'h0008, 2); wr_bytes(2'd2, 40'h0002, 2);
    wait_done(n);
    peek_stat(s);           check("R7 ovf cleared by good divide", 64'(s[6]), 64'h0);

    // R12 writes ignored while busy
    do_clear();
    wr_bytes(2'd2, 40'h4, 2); wr_bytes(2'd1, 40'h3, 2);
    wr(2'd1, 8'hEE);
    wr(2'd3, 8'h99);
    wr(2'd0, 8'h10);
    wr(2'd2, 8'h55);
    wait_done(n);
    rd_bytes(2'd1, 4, v);   check("R12 product intact", 64'(v), 64'h0000000C);
    rd_bytes(2'd3, 5, v);   check("R12 acc not cleared", 64'(v), 64'h0C);
    rd_bytes(2'd2, 2, v);   check("R12 B intact", 64'(v), 64'h0004);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule